// File: doc/BRIEF.md
# Card Socket Control and Status Registers

This block gives a processor a byte-wide register window onto one removable card socket. A single upper-address region selects the window. A write there loads an 8-bit control register, which cannot be read back. A read there returns an 8-bit status byte built from the socket pins and three internal latches. The control bits drive the socket reset, the programming-voltage switch and the address-buffer enable. They also feed the mode selections that the neighbouring access logic decodes.

Card insertion and card extraction are each caught in a latch. The socket-enable control bit arms one latch and clears the other. Software acknowledges an insertion by enabling the socket and an extraction by disabling it. A third, sticky latch records that the card raised its 16-bit I/O indication while I/O mode was active. The two event latches, the card interrupt pin and the status-change pin are merged into one interrupt request.

All socket pins are taken as already synchronised and debounced, with asserted meaning logic 1.

Top module: `card_socket_regs`

## Requirements
- R1: When `cs_i` and `wr_i` are high and `region_i` equals `REG_REGION` (default 3'b110) at a rising clock edge, all eight control bits load from `data_i`. Any write outside that region leaves the control outputs unchanged. The control bit positions are: 7 socket enable (`addr_buf_en_o`), 6 spare, 5 programming voltage (`vpp_en_o`), 4 wait-generator disable (`wait_dis_o`), 3 status-change interrupt enable, 2 byte-wide card (`byte_mode_o`), 1 card reset, 0 I/O card mode (`io_mode_o`).
- R2: While `rst_ni` is low, every control bit is 0, so the socket starts disabled, unpowered and with the wait generator on. All three latches are also 0.
- R3: `data_oe_o` is high only while `cs_i` and `rd_i` are high in the register region. When it is high, `data_o` carries the status byte. When it is low, `data_o` is 0. A read never alters the control register.
- R4: The status byte positions are: 7 card present (both detect pins high), 6 write protect, 5 ready/interrupt pin, 4 extraction latch, 3 insertion latch, 2 16-bit I/O latch, 1 `bvd2_i`, 0 `bvd1_i`.
- R5: The insertion latch sets at a clock edge where the socket enable is 0 and both detect pins are high. It then holds until a clock edge with the socket enable at 1, which clears it.
- R6: The extraction latch sets at a clock edge where the socket enable is 1 and either detect pin is low. It then holds, even if the card returns, until a clock edge with the socket enable at 0, which clears it.
- R7: The 16-bit I/O latch sets at a clock edge where socket enable and I/O mode are both 1 and `io16_i` is high. It stays set while both control bits remain 1 and clears at the first edge where either is 0.
- R8: `irq_o` is the OR of four terms: the insertion latch, the extraction latch, `rdy_irq_i` gated by I/O mode, and `bvd1_i` gated by control bit 3.
- R9: `card_rst_o` is high while `rst_ni` is low or control bit 1 is set.

Three timing rules follow from R5 to R7. A control write takes effect at the edge that captures it. The latches react one edge later. The latches sample the pins at each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Window chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| region_i | input | REGION_W | Upper address bits selecting the region |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data (status byte) |
| data_oe_o | output | 1 | Bus drive enable for `data_o` |
| det_a_i | input | 1 | Card detect pin A, asserted high |
| det_b_i | input | 1 | Card detect pin B, asserted high |
| wp_i | input | 1 | Write-protect pin |
| rdy_irq_i | input | 1 | Busy / card interrupt pin, asserted high |
| io16_i | input | 1 | Card 16-bit I/O indication |
| bvd1_i | input | 1 | Battery detect 1 / status change |
| bvd2_i | input | 1 | Battery detect 2 / speaker |
| card_rst_o | output | 1 | Socket reset |
| vpp_en_o | output | 1 | Programming-voltage enable |
| addr_buf_en_o | output | 1 | Address-buffer enable (socket enable) |
| wait_dis_o | output | 1 | Wait-generator disable |
| byte_mode_o | output | 1 | Byte-wide card mode |
| io_mode_o | output | 1 | I/O card mode |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The assertions watch four things on every cycle:
- the control register loading or holding around each qualified write;
- the set and clear edges of the insertion, extraction and 16-bit I/O latches against the socket enable;
- the bus drive enable staying low outside qualified reads;
- the interrupt and card-reset outputs covering their sources.

Some behaviour only the bench scenarios can show. These are the exact bit positions in the status byte and the control outputs, and the fact that an out-of-region write is ignored. They also include the hand-off sequences. After the socket is disabled with a card still seated, the extraction latch clears and the insertion latch re-arms one edge later. An extraction latch also holds after the card is reseated.

// File: rtl/sockreg_pkg.sv
package sockreg_pkg;

  localparam int DATA_W = 8;

  // field order sets the bit position: first field is bit 7
  typedef struct packed {
    logic sock_en;
    logic spare;
    logic vpp_en;
    logic wait_dis;
    logic schg_ien;
    logic byte_mode;
    logic card_rst;
    logic io_mode;
  } ctrl_t;

  typedef struct packed {
    logic present;
    logic wp;
    logic rdy_irq;
    logic extracted;
    logic inserted;
    logic io16_seen;
    logic bvd2;
    logic bvd1;
  } status_t;

endpackage

// File: rtl/sockreg_ctrl.sv
module sockreg_ctrl
  import sockreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] data_i,
  output ctrl_t             ctrl_o
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (wr_hit_i) ctrl_q <= ctrl_t'(data_i);
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> ctrl_q == ctrl_t'($past(data_i))); // R1
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> $stable(ctrl_q)); // R1

endmodule

// File: rtl/sockreg_events.sv
module sockreg_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sock_en_i,
  input  logic io_mode_i,
  input  logic det_a_i,
  input  logic det_b_i,
  input  logic io16_i,
  output logic inserted_o,
  output logic extracted_o,
  output logic io16_seen_o
);

  logic present;
  logic ins_q, ext_q, io16_q;

  assign present = det_a_i & det_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q  <= 1'b0;
      ext_q  <= 1'b0;
      io16_q <= 1'b0;
    end else begin
      // enable acknowledges an insertion, disable acknowledges an extraction
      ins_q  <= !sock_en_i && (ins_q || present);
      ext_q  <=  sock_en_i && (ext_q || !present);
      io16_q <=  sock_en_i && io_mode_i && (io16_q || io16_i);
    end
  end

  assign inserted_o  = ins_q;
  assign extracted_o = ext_q;
  assign io16_seen_o = io16_q;

  AST_INS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sock_en_i && det_a_i && det_b_i) |=> ins_q); // R5
  AST_INS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sock_en_i |=> !ins_q); // R5
  AST_EXT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sock_en_i && !(det_a_i && det_b_i)) |=> ext_q); // R6
  AST_EXT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sock_en_i |=> !ext_q); // R6
  AST_IO16_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sock_en_i && io_mode_i) |=> !io16_q); // R7
  AST_IO16_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io16_q && sock_en_i && io_mode_i) |=> io16_q); // R7

endmodule

// File: rtl/sockreg_status.sv
module sockreg_status
  import sockreg_pkg::*;
(
  input  logic              rd_hit_i,
  input  logic              io_mode_i,
  input  logic              schg_ien_i,
  input  logic              det_a_i,
  input  logic              det_b_i,
  input  logic              wp_i,
  input  logic              rdy_irq_i,
  input  logic              bvd1_i,
  input  logic              bvd2_i,
  input  logic              inserted_i,
  input  logic              extracted_i,
  input  logic              io16_seen_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              irq_o
);

  status_t stat;

  always_comb begin
    stat.present   = det_a_i & det_b_i;
    stat.wp        = wp_i;
    stat.rdy_irq   = rdy_irq_i;
    stat.extracted = extracted_i;
    stat.inserted  = inserted_i;
    stat.io16_seen = io16_seen_i;
    stat.bvd2      = bvd2_i;
    stat.bvd1      = bvd1_i;
  end

  assign data_oe_o = rd_hit_i;
  assign data_o    = rd_hit_i ? DATA_W'(stat) : '0;

  assign irq_o = inserted_i | extracted_i
               | (rdy_irq_i & io_mode_i)
               | (bvd1_i & schg_ien_i);

endmodule

// File: rtl/card_socket_regs.sv
module card_socket_regs
  import sockreg_pkg::*;
#(
  parameter int unsigned         REGION_W   = 3,
  parameter logic [REGION_W-1:0] REG_REGION = 3'b110
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [REGION_W-1:0] region_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                data_oe_o,
  input  logic                det_a_i,
  input  logic                det_b_i,
  input  logic                wp_i,
  input  logic                rdy_irq_i,
  input  logic                io16_i,
  input  logic                bvd1_i,
  input  logic                bvd2_i,
  output logic                card_rst_o,
  output logic                vpp_en_o,
  output logic                addr_buf_en_o,
  output logic                wait_dis_o,
  output logic                byte_mode_o,
  output logic                io_mode_o,
  output logic                irq_o
);

  logic  reg_sel, wr_hit, rd_hit;
  ctrl_t ctrl;
  logic  ins, ext, io16_seen;

  assign reg_sel = cs_i && (region_i == REG_REGION);
  assign wr_hit  = reg_sel && wr_i;
  assign rd_hit  = reg_sel && rd_i;

  sockreg_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .data_i   (data_i),
    .ctrl_o   (ctrl)
  );

  sockreg_events u_events (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sock_en_i   (ctrl.sock_en),
    .io_mode_i   (ctrl.io_mode),
    .det_a_i     (det_a_i),
    .det_b_i     (det_b_i),
    .io16_i      (io16_i),
    .inserted_o  (ins),
    .extracted_o (ext),
    .io16_seen_o (io16_seen)
  );

  sockreg_status u_status (
    .rd_hit_i    (rd_hit),
    .io_mode_i   (ctrl.io_mode),
    .schg_ien_i  (ctrl.schg_ien),
    .det_a_i     (det_a_i),
    .det_b_i     (det_b_i),
    .wp_i        (wp_i),
    .rdy_irq_i   (rdy_irq_i),
    .bvd1_i      (bvd1_i),
    .bvd2_i      (bvd2_i),
    .inserted_i  (ins),
    .extracted_i (ext),
    .io16_seen_i (io16_seen),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o),
    .irq_o       (irq_o)
  );

  assign card_rst_o    = !rst_ni || ctrl.card_rst;
  assign vpp_en_o      = ctrl.vpp_en;
  assign addr_buf_en_o = ctrl.sock_en;
  assign wait_dis_o    = ctrl.wait_dis;
  assign byte_mode_o   = ctrl.byte_mode;
  assign io_mode_o     = ctrl.io_mode;

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> !data_oe_o); // R3
  AST_READ_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !wr_i) |=> $stable(ctrl)); // R3
  AST_IRQ_EVENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins || ext) |-> irq_o); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins && !ext && !rdy_irq_i && !bvd1_i) |-> !irq_o); // R8
  AST_CARD_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.card_rst |-> card_rst_o); // R9
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (!vpp_en_o && !addr_buf_en_o && !wait_dis_o && card_rst_o)); // R2

endmodule

// File: tb/card_socket_regs_test.sv
module card_socket_regs_test;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [2:0] REG_RGN = 3'b110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, rd = 0, wr = 0;
  logic [2:0] region = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       oe;
  logic       det_a = 0, det_b = 0, wp = 0, rdy = 0, io16 = 0, bvd1 = 0, bvd2 = 0;
  logic       card_rst, vpp_en, addr_en, wait_dis, byte_mode, io_mode, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  card_socket_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .region_i(region), .data_i(wdata), .data_o(rdata), .data_oe_o(oe),
    .det_a_i(det_a), .det_b_i(det_b), .wp_i(wp), .rdy_irq_i(rdy),
    .io16_i(io16), .bvd1_i(bvd1), .bvd2_i(bvd2),
    .card_rst_o(card_rst), .vpp_en_o(vpp_en), .addr_buf_en_o(addr_en),
    .wait_dis_o(wait_dis), .byte_mode_o(byte_mode), .io_mode_o(io_mode),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] rg, input logic [7:0] v);
    cs = 1; wr = 1; region = rg; wdata = v;
    step();
    cs = 0; wr = 0; wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] rg, output logic [7:0] v, output logic drv);
    cs = 1; rd = 1; region = rg;
    #1;
    v = rdata; drv = oe;
    cs = 0; rd = 0;
    #1;
  endtask

  function automatic logic [7:0] ctrl_outs();
    return {addr_en, 1'b0, vpp_en, wait_dis, 1'b0, byte_mode, card_rst, io_mode};
  endfunction

  task automatic t_reset();
    #3;
    chk("R2 outputs in reset", ctrl_outs(), 8'h02);
    chk("R9 card reset from system reset", {7'd0, card_rst}, 8'h01);
    @(negedge clk); rst_n = 1; step();
    chk("R2 outputs after reset", ctrl_outs(), 8'h00);
    chk("R2 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] v; logic d;
    bus_write(REG_RGN, 8'h35);
    chk("R1 control load", ctrl_outs(), 8'h35);
    bus_write(3'b111, 8'h82);
    chk("R1 out-of-region write ignored", ctrl_outs(), 8'h35);
    bus_read(REG_RGN, v, d);
    step();
    chk("R3 read leaves control", ctrl_outs(), 8'h35);
    bus_write(REG_RGN, 8'h02);
    chk("R9 card reset from control", {7'd0, card_rst}, 8'h01);
    bus_write(REG_RGN, 8'h00);
    chk("R9 card reset released", {7'd0, card_rst}, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v; logic d;
    wp = 1; bvd2 = 1; rdy = 1;
    bus_read(REG_RGN, v, d);
    chk("R3 drive on read", {7'd0, d}, 8'h01);
    chk("R4 status pins", v, 8'h62);
    bus_read(3'b101, v, d);
    chk("R3 no drive outside region", {7'd0, d}, 8'h00);
    chk("R3 data zero when idle", v, 8'h00);
    chk("R8 card irq gated off in memory mode", {7'd0, irq}, 8'h00);
    wp = 0; bvd2 = 0; rdy = 0;
  endtask

  task automatic t_events();
    logic [7:0] v; logic d;
    det_a = 1; det_b = 1; step();
    bus_read(REG_RGN, v, d);
    chk("R5 insertion latched", v, 8'h88);
    chk("R8 irq from insertion", {7'd0, irq}, 8'h01);
    det_a = 0; step(); det_a = 1;
    bus_read(REG_RGN, v, d);
    chk("R5 insertion holds while disabled", v, 8'h88);
    bus_write(REG_RGN, 8'h80); step();
    bus_read(REG_RGN, v, d);
    chk("R5 insertion cleared by enable", v, 8'h80);
    chk("R8 irq idle", {7'd0, irq}, 8'h00);
    det_b = 0; step(); det_b = 1; step();
    bus_read(REG_RGN, v, d);
    chk("R6 extraction holds after reseat", v, 8'h90);
    chk("R8 irq from extraction", {7'd0, irq}, 8'h01);
    bus_write(REG_RGN, 8'h00); step();
    bus_read(REG_RGN, v, d);
    chk("R6 extraction cleared, R5 re-armed", v, 8'h88);
    bus_write(REG_RGN, 8'h80); step();
  endtask

  task automatic t_io16();
    logic [7:0] v; logic d;
    io16 = 1; step(); io16 = 0;
    bus_read(REG_RGN, v, d);
    chk("R7 no latch outside I/O mode", v, 8'h80);
    bus_write(REG_RGN, 8'h81);
    io16 = 1; step(); io16 = 0; step();
    bus_read(REG_RGN, v, d);
    chk("R7 io16 latched and sticky", v, 8'h84);
    rdy = 1; #1;
    chk("R8 card irq in I/O mode", {7'd0, irq}, 8'h01);
    bus_write(REG_RGN, 8'h80); step();
    bus_read(REG_RGN, v, d);
    chk("R7 io16 cleared leaving I/O mode", v, 8'hA0);
    chk("R8 card irq gated off", {7'd0, irq}, 8'h00);
    rdy = 0;
  endtask

  task automatic t_schg();
    bvd1 = 1; #1;
    chk("R8 status change gated off", {7'd0, irq}, 8'h00);
    bus_write(REG_RGN, 8'h88); #1;
    chk("R8 status change enabled", {7'd0, irq}, 8'h01);
    bvd1 = 0; #1;
    chk("R8 status change released", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_ctrl();
    t_status();
    t_events();
    t_io16();
    t_schg();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule